// File: doc/BRIEF.md
# Handshaked Serial Byte-Link Slave with Reset Sequencing

This block is the peripheral end of a host-clocked serial link. The host produces the bit clock and one data line. The slave tells the host it can take a byte by pulling an active-low ready line low. It takes in eight bits, most significant first, on eight rising host-clock edges. After the last bit it raises ready for a fixed number of system-clock cycles, which is the time it needs to process the byte. It then lowers ready again for the next byte. Each completed byte appears on a parallel output together with a one-cycle valid pulse.

The same block also sequences the system reset. After power-on it holds system reset low until the power-good input is high and the host halt input is inactive. When power-good falls, it raises an interrupt request to the host. It then waits for the host to lower its halt line and drives system reset low when that happens. If the host does not lower halt within a bounded number of cycles, the slave forces reset low anyway. Every asynchronous input passes through a two-flop synchroniser before it is used.

Top module: `byte_link_slave`

## Requirements
- R1: While and just after `porN` is low, `sysRstN`=0, `readyN`=1, `irqN`=1, `rxValid`=0 and `overrun`=0.
- R2: With `hostHaltN` high, a rising `pwrGood` raises `sysRstN` on the third system clock after the input changes. `readyN` falls one cycle after `sysRstN` rises, and `readyN` is never low while `sysRstN` is low.
- R3: While `readyN` is low, each rising edge of `hostClk` shifts in `hostData`, most significant bit first. After the eighth edge, `rxByte` holds the byte and `rxValid` is high for exactly one cycle, three system clocks after that edge reaches the input.
- R4: `readyN` rises in the same cycle as `rxValid`. It stays high for exactly `PROC_CYCLES` cycles and then returns low.
- R5: A rising `hostClk` edge while `readyN` is high and `sysRstN` is high produces a one-cycle `overrun` pulse. That edge shifts no bit, so the next byte is received intact.
- R6: A falling `pwrGood` while the system is running drives `irqN` low three cycles later and holds `readyN` high. Any partially received byte is discarded.
- R7: A low `hostHaltN` in any powered state drives `sysRstN` low three cycles later, and `irqN` returns high.
- R8: If `hostHaltN` stays high after a power-fail interrupt, `sysRstN` is forced low after exactly `STOP_WAIT` cycles of `irqN` low.
- R9: `sysRstN` stays low while either `pwrGood` is low or `hostHaltN` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| hostClk | input | 1 | Serial bit clock from the host, idle low |
| hostData | input | 1 | Serial data from the host, sampled on rising hostClk |
| pwrGood | input | 1 | Power-good indication, high when supply is healthy |
| hostHaltN | input | 1 | Host halt request, active low |
| sysRstN | output | 1 | System reset, active low |
| readyN | output | 1 | Byte-accept ready, active low |
| irqN | output | 1 | Power-fail interrupt request, active low |
| rxByte | output | BITS | Last received byte |
| rxValid | output | 1 | One-cycle pulse when rxByte updates |
| overrun | output | 1 | One-cycle pulse on a host clock edge while not ready |

## Verification
The assertions assume that `hostClk`, `hostData`, `pwrGood` and `hostHaltN` are quasi-static compared with the system clock. Each level must be held for several cycles so that the synchronised copies follow it one for one, and data must be stable around each rising host-clock edge. The stimulus drives every input just after a falling system-clock edge. It holds each host-clock phase and each data bit for four cycles, and it changes power-good and halt only once per scenario. As a result, no edge is lost in the synchronisers and the expected latencies stay exact.

// File: rtl/bls_pkg.sv
package bls_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_SETTLE,
    ST_READY,
    ST_PROC,
    ST_DOWN
  } linkState_t;

  typedef struct packed {
    logic shiftEn;
    logic clrBits;
    logic loadProc;
    logic tickProc;
    logic loadWait;
    logic tickWait;
  } strobes_t;

endpackage

// File: rtl/bls_sync.sv
module bls_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] pipe;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pipe[0] <= '0;
    else     pipe[0] <= din;
  end

  generate
    for (genvar i = 1; i < STAGES; i++) begin : gStage
      always_ff @(posedge clk or posedge rst) begin
        if (rst) pipe[i] <= '0;
        else     pipe[i] <= pipe[i-1];
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/bls_dpath.sv
module bls_dpath
  import bls_pkg::*;
#(
  parameter int BITS = 8,
  parameter int PROC_CYCLES = 16,
  parameter int STOP_WAIT = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  strobes_t        strb,
  input  logic            hostClk,
  input  logic            hostData,
  input  logic            pwrGood,
  input  logic            hostHaltN,
  output logic            sclkRise,
  output logic            lastBit,
  output logic            procDone,
  output logic            waitDone,
  output logic            pfOk,
  output logic            haltOk,
  output logic [BITS-1:0] rxByte,
  output logic            rxValid
);
  localparam int BW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam int PW = $clog2(PROC_CYCLES + 1);
  localparam int WW = $clog2(STOP_WAIT + 1);
  localparam logic [BW-1:0] LAST_IDX  = BW'(BITS - 1);
  localparam logic [PW-1:0] PROC_LOAD = PW'(PROC_CYCLES - 1);
  localparam logic [WW-1:0] WAIT_LOAD = WW'(STOP_WAIT - 1);

  logic [3:0] syncOut;
  logic sclkS, sdataS, sclkPrev;
  logic [BITS-1:0] shiftReg;
  logic [BW-1:0]   bitCnt;
  logic [PW-1:0]   procCnt;
  logic [WW-1:0]   waitCnt;

  bls_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) uSync (
    .clk (clk),
    .rst (rst),
    .din ({hostClk, hostData, pwrGood, hostHaltN}),
    .dout(syncOut)
  );

  assign sclkS  = syncOut[3];
  assign sdataS = syncOut[2];
  assign pfOk   = syncOut[1];
  assign haltOk = syncOut[0];

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sclkPrev <= 1'b0;
    else     sclkPrev <= sclkS;
  end

  assign sclkRise = sclkS & ~sclkPrev;
  assign lastBit  = (bitCnt == LAST_IDX);
  assign procDone = (procCnt == '0);
  assign waitDone = (waitCnt == '0);

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (strb.clrBits) begin
      bitCnt   <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[BITS-2:0], sdataS};
      bitCnt   <= lastBit ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      rxByte  <= '0;
      rxValid <= 1'b0;
    end else begin
      rxValid <= strb.shiftEn & lastBit;
      if (strb.shiftEn && lastBit) rxByte <= {shiftReg[BITS-2:0], sdataS};
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                            procCnt <= '0;
    else if (strb.loadProc)             procCnt <= PROC_LOAD;
    else if (strb.tickProc && !procDone) procCnt <= procCnt - 1'b1;
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst)                            waitCnt <= '0;
    else if (strb.loadWait)             waitCnt <= WAIT_LOAD;
    else if (strb.tickWait && !waitDone) waitCnt <= waitCnt - 1'b1;
  end

  AST_SHIFT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    strb.shiftEn |-> sclkRise) else $error("shift without host edge"); // R3
  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rxValid |=> !rxValid) else $error("valid longer than one cycle"); // R3
  AST_NO_SHIFT_WHEN_CLR: assert property (@(posedge clk) disable iff (rst)
    strb.clrBits |=> !rxValid) else $error("byte completed while cleared"); // R6
endmodule

// File: rtl/bls_ctrl.sv
module bls_ctrl
  import bls_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     sclkRise,
  input  logic     lastBit,
  input  logic     procDone,
  input  logic     waitDone,
  input  logic     pfOk,
  input  logic     haltOk,
  output strobes_t strb,
  output logic     sysRstN,
  output logic     readyN,
  output logic     irqN,
  output logic     overrun
);
  linkState_t state, stateNxt;
  logic overrunNxt;

  always_comb begin
    stateNxt = state;
    strb = '0;
    overrunNxt = 1'b0;
    unique case (state)
      ST_OFF: begin
        strb.clrBits = 1'b1;
        if (pfOk && haltOk) stateNxt = ST_SETTLE;
      end
      ST_SETTLE: begin
        strb.clrBits = 1'b1;
        overrunNxt = sclkRise;
        if (!haltOk) stateNxt = ST_OFF;
        else if (!pfOk) begin
          stateNxt = ST_DOWN;
          strb.loadWait = 1'b1;
        end else stateNxt = ST_READY;
      end
      ST_READY: begin
        if (!haltOk) stateNxt = ST_OFF;
        else if (!pfOk) begin
          stateNxt = ST_DOWN;
          strb.loadWait = 1'b1;
          strb.clrBits = 1'b1;
        end else if (sclkRise) begin
          strb.shiftEn = 1'b1;
          if (lastBit) begin
            stateNxt = ST_PROC;
            strb.loadProc = 1'b1;
          end
        end
      end
      ST_PROC: begin
        overrunNxt = sclkRise;
        strb.tickProc = 1'b1;
        if (!haltOk) stateNxt = ST_OFF;
        else if (!pfOk) begin
          stateNxt = ST_DOWN;
          strb.loadWait = 1'b1;
        end else if (procDone) stateNxt = ST_READY;
      end
      ST_DOWN: begin
        overrunNxt = sclkRise;
        strb.clrBits = 1'b1;
        strb.tickWait = 1'b1;
        if (!haltOk || waitDone) stateNxt = ST_OFF;
      end
      default: stateNxt = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= ST_OFF;
      overrun <= 1'b0;
    end else begin
      state   <= stateNxt;
      overrun <= overrunNxt;
    end
  end

  assign sysRstN = (state != ST_OFF);
  assign readyN  = (state != ST_READY);
  assign irqN    = (state != ST_DOWN);

  AST_READY_IN_RESET: assert property (@(posedge clk) disable iff (rst)
    !readyN |-> sysRstN) else $error("ready while reset"); // R2
  AST_RELEASE_GATED: assert property (@(posedge clk) disable iff (rst)
    $rose(sysRstN) |-> $past(pfOk && haltOk)) else $error("early release"); // R9
  AST_HALT_RESETS: assert property (@(posedge clk) disable iff (rst)
    (sysRstN && !haltOk) |=> !sysRstN) else $error("halt ignored"); // R7
  AST_IRQ_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    !irqN |-> readyN) else $error("ready during power fail"); // R6
  AST_OVERRUN_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    overrun |-> $past(readyN && sysRstN)) else $error("bad overrun"); // R5
  AST_NO_SHIFT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    strb.shiftEn |-> !readyN) else $error("shift while not ready"); // R5
endmodule

// File: rtl/byte_link_slave.sv
module byte_link_slave
  import bls_pkg::*;
#(
  parameter int BITS = 8,
  parameter int PROC_CYCLES = 16,
  parameter int STOP_WAIT = 1250000,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            porN,
  input  logic            hostClk,
  input  logic            hostData,
  input  logic            pwrGood,
  input  logic            hostHaltN,
  output logic            sysRstN,
  output logic            readyN,
  output logic            irqN,
  output logic [BITS-1:0] rxByte,
  output logic            rxValid,
  output logic            overrun
);
  logic [1:0] rstPipe;
  logic rst;
  strobes_t strb;
  logic sclkRise, lastBit, procDone, waitDone, pfOk, haltOk;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) rstPipe <= 2'b00;
    else       rstPipe <= {rstPipe[0], 1'b1};
  end
  assign rst = ~rstPipe[1];

  bls_dpath #(
    .BITS(BITS), .PROC_CYCLES(PROC_CYCLES),
    .STOP_WAIT(STOP_WAIT), .SYNC_STAGES(SYNC_STAGES)
  ) uDpath (
    .clk(clk), .rst(rst), .strb(strb),
    .hostClk(hostClk), .hostData(hostData),
    .pwrGood(pwrGood), .hostHaltN(hostHaltN),
    .sclkRise(sclkRise), .lastBit(lastBit),
    .procDone(procDone), .waitDone(waitDone),
    .pfOk(pfOk), .haltOk(haltOk),
    .rxByte(rxByte), .rxValid(rxValid)
  );

  bls_ctrl uCtrl (
    .clk(clk), .rst(rst),
    .sclkRise(sclkRise), .lastBit(lastBit),
    .procDone(procDone), .waitDone(waitDone),
    .pfOk(pfOk), .haltOk(haltOk),
    .strb(strb),
    .sysRstN(sysRstN), .readyN(readyN),
    .irqN(irqN), .overrun(overrun)
  );
endmodule

// File: tb/sim_byte_link_slave.sv
`timescale 1ns/1ps
module sim_byte_link_slave;
  localparam int BITS = 8;
  localparam int PROC = 20;
  localparam int WAITC = 50;

  logic clk = 1'b0;
  logic porN = 1'b0, hostClk = 1'b0, hostData = 1'b0, pwrGood = 1'b0, hostHaltN = 1'b1;
  logic sysRstN, readyN, irqN, rxValid, overrun;
  logic [BITS-1:0] rxByte;
  int checks = 0, errors = 0, ovrSeen = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  byte_link_slave #(.BITS(BITS), .PROC_CYCLES(PROC), .STOP_WAIT(WAITC)) u0 (
    .clk(clk), .porN(porN), .hostClk(hostClk), .hostData(hostData),
    .pwrGood(pwrGood), .hostHaltN(hostHaltN), .sysRstN(sysRstN),
    .readyN(readyN), .irqN(irqN), .rxByte(rxByte), .rxValid(rxValid),
    .overrun(overrun)
  );

  always @(negedge clk) if (overrun) ovrSeen++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    porN = 1'b0;
    wait_n(4);
    check(sysRstN == 0 && readyN == 1 && irqN == 1, "R1 outputs in reset",
          {sysRstN, readyN, irqN}, 3'b011);
    porN = 1'b1;
    wait_n(6);
    check(sysRstN == 0 && readyN == 1 && irqN == 1 && rxValid == 0 && overrun == 0,
          "R1 outputs after reset", {sysRstN, readyN, irqN, rxValid, overrun}, 5'b01100);
    check(sysRstN == 0, "R9 reset held without power good", sysRstN, 0);
  endtask

  task automatic t_power_up;
    @(negedge clk); pwrGood = 1'b1;
    wait_n(2);
    check(sysRstN == 0, "R2 reset still low after two cycles", sysRstN, 0);
    wait_n(1);
    check(sysRstN == 1 && readyN == 1, "R2 reset released, ready not yet",
          {sysRstN, readyN}, 2'b11);
    wait_n(1);
    check(readyN == 0, "R2 ready one cycle after release", readyN, 0);
  endtask

  task automatic send_bit(input bit b);
    @(negedge clk); hostData = b;
    wait_n(3);
    hostClk = 1'b1;
    wait_n(4);
    hostClk = 1'b0;
    wait_n(4);
  endtask

  task automatic send_byte(input logic [BITS-1:0] v, input bit injectOvr);
    int n;
    int ovrBefore;
    for (int i = BITS - 1; i > 0; i--) send_bit(v[i]);
    @(negedge clk); hostData = v[0];
    wait_n(3);
    hostClk = 1'b1;
    wait_n(3);
    check(rxValid == 1, "R3 valid after eighth edge", rxValid, 1);
    check(rxByte == v, "R3 byte value msb first", rxByte, v);
    check(readyN == 1, "R4 ready rises with valid", readyN, 1);
    hostClk = 1'b0;
    ovrBefore = ovrSeen;
    n = 0;
    while (readyN && n < 1000) begin
      n++;
      @(negedge clk);
      if (n == 1) check(rxValid == 0, "R3 valid is one cycle", rxValid, 0);
      if (injectOvr && n == 5) hostClk = 1'b1;
      if (injectOvr && n == 10) hostClk = 1'b0;
    end
    check(n == PROC, "R4 busy interval length", n, PROC);
    if (injectOvr)
      check(ovrSeen - ovrBefore == 1, "R5 overrun pulse on edge while busy",
            ovrSeen - ovrBefore, 1);
    wait_n(6);
  endtask

  task automatic t_back_to_back;
    send_byte(8'hA5, 1'b0);
    send_byte(8'h3C, 1'b0);
    send_byte(8'h01, 1'b0);
    check(ovrSeen == 0, "R5 no overrun in clean traffic", ovrSeen, 0);
  endtask

  task automatic t_overrun;
    send_byte(8'hF0, 1'b1);
    send_byte(8'h96, 1'b0);
  endtask

  task automatic t_fail_with_halt;
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    @(negedge clk); pwrGood = 1'b0;
    wait_n(2);
    check(irqN == 1, "R6 irq not yet", irqN, 1);
    wait_n(1);
    check(irqN == 0 && readyN == 1 && sysRstN == 1, "R6 irq raised, not ready",
          {irqN, readyN, sysRstN}, 3'b011);
    @(negedge clk); hostHaltN = 1'b0;
    wait_n(3);
    check(sysRstN == 0 && irqN == 1, "R7 halt drives reset low",
          {sysRstN, irqN}, 2'b01);
    @(negedge clk); hostHaltN = 1'b1;
    wait_n(10);
    check(sysRstN == 0, "R9 reset held while power low", sysRstN, 0);
    t_power_up();
    send_byte(8'h5A, 1'b0);
  endtask

  task automatic t_fail_timeout;
    int n;
    @(negedge clk); pwrGood = 1'b0;
    n = 0;
    while (irqN && n < 100) begin n++; @(negedge clk); end
    n = 0;
    while (sysRstN && n < 1000) begin n++; @(negedge clk); end
    check(n == WAITC, "R8 forced reset after wait window", n, WAITC);
    check(irqN == 1, "R8 irq cleared with reset", irqN, 1);
    t_power_up();
  endtask

  task automatic t_halt_in_run;
    @(negedge clk); hostHaltN = 1'b0;
    wait_n(3);
    check(sysRstN == 0, "R7 halt in run drives reset", sysRstN, 0);
    wait_n(10);
    check(sysRstN == 0, "R9 reset held while halt low", sysRstN, 0);
    @(negedge clk); hostHaltN = 1'b1;
    wait_n(3);
    check(sysRstN == 1, "R9 release after halt returns", sysRstN, 1);
    wait_n(1);
    check(readyN == 0, "R2 ready after halt release", readyN, 0);
    send_byte(8'hC3, 1'b0);
  endtask

  initial begin
    t_reset();
    t_power_up();
    t_back_to_back();
    t_overrun();
    t_fail_with_halt();
    t_fail_timeout();
    t_halt_in_run();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule